// File: doc/BRIEF.md
# Dual-Mode Serial Wire-End Timestamper

This block sits beside the receiver of a half-duplex serial bus. It records the free-running clock tick at which the last stop bit of a host request left the wire. A reply scheduler later uses that tick as the origin of its reply delay. The deserializer and the packet parser sit outside the block. The deserializer supplies a one-cycle strobe as each stop bit completes, and it also supplies the raw line level and the bit period in clock ticks.

Two capture modes exist. In per-byte mode, every stop bit overwrites a one-entry snapshot that holds the running byte position and the tick. In quiet-line mode, the block waits until the line has stayed at mark level for nine bit periods. It then subtracts those nine bit periods from the detection tick and queues the pair (cumulative byte count, corrected tick). A selector chooses between the modes. Per-byte mode is used whenever one character time plus a programmable margin exceeds the reply delay, because in that case a quiet-line event would arrive after the reply deadline.

The parser finds the end of a request and then presents the byte position of that end on a lookup port. One cycle later it receives either the matching tick or "unknown".

Top module: `wire_end_stamper`

## Requirements
- R1: `tick_now` is 0 while in reset and increases by exactly 1 on every clock, wrapping at 2^32.
- R2: `rx_count` is 0 after reset and increases by 1 (mod 2^16) in the cycle after each `byte_stb` pulse.
- R3: `per_byte_mode` is 1 after reset. One cycle after the inputs are applied it equals (9,000,000 + margin_us × baud_hz > 2 × rdt_code × baud_hz). Here `rdt_code` counts 2 µs units, so the rule means char time + margin > reply delay.
- R4: With `rdt_code` = 1 (2 µs), `per_byte_mode` is 1 one cycle later.
- R5: In per-byte mode, a `byte_stb` overwrites the snapshot with (count after that byte, `tick_now` of the strobe cycle). In quiet-line mode the snapshot is not changed.
- R6: A per-byte-mode lookup reports found with the snapshot tick only when a snapshot exists and its position equals `lookup_pos`. The snapshot is not consumed.
- R7: A quiet-line event occurs when `rx_line` has stayed high for 9 × `baud_div` cycles after a strobe, in the cycle where the strobe-relative count reaches 9 × `baud_div`. A low cycle on `rx_line` before that point cancels the event.
- R8: Only in quiet-line mode does each event queue (`rx_count`, `tick_now` − 9 × `baud_div`). That tick equals the tick of the last strobe.
- R9: A quiet-line-mode lookup returns the oldest queued entry whose count equals `lookup_pos` and removes that entry. When no entry matches, found is 0. A push in the same cycle is not visible to the search.
- R10: The queue holds 4 entries. A push into a full queue (after any same-cycle removal) discards the oldest entry and sets `fifo_overflow`, which stays 1 until reset.
- R11: `lookup_valid` is high exactly in the cycle after a `lookup_req` cycle. When found is 0, `lookup_tick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously to clk |
| rx_line | input | 1 | Raw receive line level, 1 = mark |
| byte_stb | input | 1 | One-cycle pulse as a stop bit completes |
| baud_div | input | 16 | Clock ticks per bit |
| baud_hz | input | 22 | Bus rate in bit/s |
| rdt_code | input | 8 | Reply delay in 2 µs units |
| margin_us | input | 10 | Processing margin in µs (20 is the usual setting) |
| lookup_req | input | 1 | Lookup request strobe |
| lookup_pos | input | 16 | Byte position of the parsed request end |
| lookup_valid | output | 1 | Lookup result present |
| lookup_found | output | 1 | Tick known for the requested position |
| lookup_tick | output | 32 | Wire-end tick, 0 when not found |
| tick_now | output | 32 | Free-running tick counter |
| rx_count | output | 16 | Cumulative received byte count |
| per_byte_mode | output | 1 | 1 = per-byte capture, 0 = quiet-line capture |
| fifo_overflow | output | 1 | Sticky: a queued stamp was discarded |

## Verification
A wrong internal state shows up at the ports in specific ways. A corrupted queue entry or a lost entry appears as a wrong or missing tick on the next lookup for that position, one cycle after the request. A miscounted quiet-line timer either misses the event or stamps it with a shifted tick, and in both cases the next lookup exposes it. A mode decision that goes the wrong way appears on `per_byte_mode` in the very next cycle. A wrong mode also changes which structure answers the following lookup. Because the reference model is compared on every clock, a divergence is reported in the cycle it first becomes visible at a port.

// File: rtl/wes_pkg.sv
package wes_pkg;
  parameter int unsigned WES_TICK_W = 32;
  parameter int unsigned WES_POS_W  = 16;

  typedef struct packed {
    logic [WES_POS_W-1:0]  pos;
    logic [WES_TICK_W-1:0] tick;
  } stamp_t;
endpackage

// File: rtl/wes_mode_sel.sv
module wes_mode_sel #(
  parameter int unsigned BAUD_W   = 22,
  parameter int unsigned RDT_W    = 8,
  parameter int unsigned MARGIN_W = 10,
  parameter int unsigned CHAR_NUM = 9_000_000,
  parameter int unsigned STEP_US  = 2,
  localparam int unsigned PROD_W  = BAUD_W + ((MARGIN_W > RDT_W) ? MARGIN_W : RDT_W) + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BAUD_W-1:0]   baud_hz,
  input  logic [RDT_W-1:0]    rdt_code,
  input  logic [MARGIN_W-1:0] margin_us,
  output logic                per_byte
);
  logic [PROD_W-1:0] late_side;
  logic [PROD_W-1:0] budget_side;
  logic              per_byte_d;

  // Cross-multiplied by baud_hz so no divider is needed.
  always_comb begin
    late_side   = PROD_W'(CHAR_NUM) + PROD_W'(margin_us) * PROD_W'(baud_hz);
    budget_side = PROD_W'(STEP_US) * PROD_W'(rdt_code) * PROD_W'(baud_hz);
    per_byte_d  = (late_side > budget_side);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_byte <= 1'b1;
    else        per_byte <= per_byte_d;
  end
endmodule

// File: rtl/wes_idle_detect.sv
module wes_idle_detect #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned IDLE_BITS = 9,
  localparam int unsigned CNT_W    = DIV_W + $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             byte_stb,
  input  logic [DIV_W-1:0] baud_div,
  output logic             idle_evt,
  output logic [CNT_W-1:0] idle_span
);
  logic             armed_q, armed_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    idle_span = CNT_W'(IDLE_BITS) * CNT_W'(baud_div);
    idle_evt  = armed_q && rx_line && !byte_stb && (cnt_q == idle_span);
    armed_d   = armed_q;
    cnt_d     = cnt_q;
    cnt_en    = 1'b0;
    if (byte_stb) begin
      armed_d = 1'b1;
      cnt_d   = CNT_W'(1);
      cnt_en  = 1'b1;
    end else if (armed_q) begin
      if (!rx_line || idle_evt) begin
        armed_d = 1'b0;
      end else begin
        cnt_d  = cnt_q + CNT_W'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wes_stamp_fifo.sv
module wes_stamp_fifo
  import wes_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  stamp_t                push_ent,
  input  logic                  lk_en,
  input  logic [WES_POS_W-1:0]  lk_pos,
  output logic                  hit,
  output logic [WES_TICK_W-1:0] hit_tick,
  output logic                  overflow
);
  stamp_t           ent_q [DEPTH];
  stamp_t           ent_d [DEPTH];
  stamp_t           rm_ent[DEPTH];
  logic [DEPTH-1:0] vld_q, vld_d, rm_vld;
  logic [IDX_W-1:0] hit_idx, rm_cnt;
  logic             ovf_d;
  logic             wr_en;

  // Search: lowest index (oldest) match wins.
  always_comb begin
    hit      = 1'b0;
    hit_idx  = '0;
    hit_tick = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && ent_q[i].pos == lk_pos) begin
        hit      = 1'b1;
        hit_idx  = IDX_W'(i);
        hit_tick = ent_q[i].tick;
      end
    end
  end

  // Removal closes the gap, then the push lands on the compacted queue.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (lk_en && hit && IDX_W'(i) >= hit_idx) begin
        rm_ent[i] = ent_q[(i + 1 < DEPTH) ? i + 1 : i];
        rm_vld[i] = (i + 1 < DEPTH) ? vld_q[(i + 1 < DEPTH) ? i + 1 : i] : 1'b0;
      end else begin
        rm_ent[i] = ent_q[i];
        rm_vld[i] = vld_q[i];
      end
    end
    rm_cnt = IDX_W'($countones(rm_vld));
    ent_d  = rm_ent;
    vld_d  = rm_vld;
    ovf_d  = overflow;
    if (push) begin
      if (rm_cnt == IDX_W'(DEPTH)) begin
        for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = rm_ent[i + 1];
        ent_d[DEPTH-1] = push_ent;
        ovf_d          = 1'b1;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if (IDX_W'(i) == rm_cnt) begin
            ent_d[i] = push_ent;
            vld_d[i] = 1'b1;
          end
        end
      end
    end
    wr_en = push || lk_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_en) vld_q <= vld_d;
      overflow <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent_q <= ent_d;
  end
endmodule

// File: rtl/wire_end_stamper.sv
module wire_end_stamper
  import wes_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned BAUD_W    = 22,
  parameter int unsigned RDT_W     = 8,
  parameter int unsigned MARGIN_W  = 10,
  parameter int unsigned IDLE_BITS = 9,
  localparam int unsigned SPAN_W   = DIV_W + $clog2(IDLE_BITS + 1),
  localparam int unsigned POS_W    = WES_POS_W,
  localparam int unsigned TICK_W   = WES_TICK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  input  logic                byte_stb,
  input  logic [DIV_W-1:0]    baud_div,
  input  logic [BAUD_W-1:0]   baud_hz,
  input  logic [RDT_W-1:0]    rdt_code,
  input  logic [MARGIN_W-1:0] margin_us,
  input  logic                lookup_req,
  input  logic [POS_W-1:0]    lookup_pos,
  output logic                lookup_valid,
  output logic                lookup_found,
  output logic [TICK_W-1:0]   lookup_tick,
  output logic [TICK_W-1:0]   tick_now,
  output logic [POS_W-1:0]    rx_count,
  output logic                per_byte_mode,
  output logic                fifo_overflow
);
  logic              idle_evt;
  logic [SPAN_W-1:0] idle_span;
  logic              q_push, q_lk_en, q_hit;
  logic [TICK_W-1:0] q_tick;
  stamp_t            q_ent;

  logic              snap_v_q;
  stamp_t            snap_q, snap_d;
  logic              snap_en;
  logic              pb_hit;
  logic [POS_W-1:0]  count_d;
  logic              found_d;
  logic [TICK_W-1:0] res_tick_d;

  wes_mode_sel #(
    .BAUD_W(BAUD_W), .RDT_W(RDT_W), .MARGIN_W(MARGIN_W),
    .CHAR_NUM(IDLE_BITS * 1_000_000), .STEP_US(2)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .baud_hz(baud_hz), .rdt_code(rdt_code),
    .margin_us(margin_us), .per_byte(per_byte_mode)
  );

  wes_idle_detect #(.DIV_W(DIV_W), .IDLE_BITS(IDLE_BITS)) u_idle (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .byte_stb(byte_stb),
    .baud_div(baud_div), .idle_evt(idle_evt), .idle_span(idle_span)
  );

  wes_stamp_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_ent(q_ent),
    .lk_en(q_lk_en), .lk_pos(lookup_pos), .hit(q_hit), .hit_tick(q_tick),
    .overflow(fifo_overflow)
  );

  always_comb begin
    count_d     = rx_count + POS_W'(1);
    q_push      = idle_evt && !per_byte_mode;
    q_ent.pos   = rx_count;
    q_ent.tick  = tick_now - TICK_W'(idle_span);   // backdate to the stop bit
    q_lk_en     = lookup_req && !per_byte_mode;
    snap_en     = byte_stb && per_byte_mode;
    snap_d.pos  = count_d;
    snap_d.tick = tick_now;
    pb_hit      = snap_v_q && (snap_q.pos == lookup_pos);
    found_d     = lookup_req && (per_byte_mode ? pb_hit : q_hit);
    res_tick_d  = '0;
    if (found_d) res_tick_d = per_byte_mode ? snap_q.tick : q_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_now     <= '0;
      rx_count     <= '0;
      snap_v_q     <= 1'b0;
      lookup_valid <= 1'b0;
      lookup_found <= 1'b0;
      lookup_tick  <= '0;
    end else begin
      tick_now <= tick_now + TICK_W'(1);
      if (byte_stb) rx_count <= count_d;
      if (snap_en)  snap_v_q <= 1'b1;
      lookup_valid <= lookup_req;
      lookup_found <= found_d;
      lookup_tick  <= res_tick_d;
    end
  end

  always_ff @(posedge clk) begin
    if (snap_en) snap_q <= snap_d;
  end
endmodule

// File: rtl/wes_checker.sv
module wes_checker
  import wes_pkg::*;
#(
  parameter int unsigned RDT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  byte_stb,
  input logic [RDT_W-1:0]      rdt_code,
  input logic                  lookup_req,
  input logic                  lookup_valid,
  input logic                  lookup_found,
  input logic [WES_TICK_W-1:0] tick_now,
  input logic [WES_POS_W-1:0]  rx_count,
  input logic                  per_byte_mode,
  input logic                  fifo_overflow
);
  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> tick_now == $past(tick_now) + WES_TICK_W'(1));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> rx_count == $past(rx_count) + WES_POS_W'(1));

  assert_min_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(rdt_code) == RDT_W'(1) |-> per_byte_mode);

  assert_no_push_perbyte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    per_byte_mode |=> $stable(fifo_overflow));

  assert_sticky_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_overflow |=> fifo_overflow);

  assert_reply_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_req |=> lookup_valid);

  assert_no_spurious_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_req |=> !lookup_valid);

  assert_found_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_found |-> lookup_valid);
endmodule

bind wire_end_stamper wes_checker #(.RDT_W(RDT_W)) u_wes_checker (
  .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .rdt_code(rdt_code),
  .lookup_req(lookup_req), .lookup_valid(lookup_valid), .lookup_found(lookup_found),
  .tick_now(tick_now), .rx_count(rx_count), .per_byte_mode(per_byte_mode),
  .fifo_overflow(fifo_overflow)
);

// File: tb/tb_wire_end_stamper.sv
module tb_wire_end_stamper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_line = 1'b1;
  logic        byte_stb = 1'b0;
  logic [15:0] baud_div = 16'd2;
  logic [21:0] baud_hz = 22'd9600;
  logic [7:0]  rdt_code = 8'd125;
  logic [9:0]  margin_us = 10'd20;
  logic        lookup_req = 1'b0;
  logic [15:0] lookup_pos = '0;
  logic        lookup_valid, lookup_found, per_byte_mode, fifo_overflow;
  logic [31:0] lookup_tick, tick_now;
  logic [15:0] rx_count;

  always #4 clk = ~clk;

  wire_end_stamper dut (.*);

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] m_tick;
  logic [15:0] m_count;
  bit          m_mode, m_ovf, m_snap_v, m_armed;
  logic [15:0] m_snap_pos;
  logic [31:0] m_snap_tick;
  int          m_idle;
  bit [47:0]   m_q[$];
  bit          e_valid, e_found;
  logic [31:0] e_tick;
  string       e_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tick = 0; m_count = 0; m_mode = 1; m_ovf = 0; m_snap_v = 0;
      m_armed = 0; m_idle = 0; m_q.delete();
      e_valid = 0; e_found = 0; e_tick = 0; e_tag = "R11";
    end else begin
      bit  fire;
      int  span;
      longint late_side, budget;
      span = 9 * int'(baud_div);
      e_valid = lookup_req; e_found = 0; e_tick = 0;
      if (lookup_req) begin
        if (m_mode) begin
          e_tag = "R5 R6";
          if (m_snap_v && m_snap_pos == lookup_pos) begin e_found = 1; e_tick = m_snap_tick; end
        end else begin
          e_tag = "R7 R8 R9";
          foreach (m_q[i]) begin
            if (m_q[i][47:32] == lookup_pos) begin
              e_found = 1; e_tick = m_q[i][31:0]; m_q.delete(i); break;
            end
          end
        end
      end
      fire = m_armed && rx_line && !byte_stb && (m_idle == span);
      if (byte_stb) begin m_armed = 1; m_idle = 1; end
      else if (m_armed) begin
        if (!rx_line || fire) m_armed = 0;
        else m_idle++;
      end
      if (fire && !m_mode) begin
        if (m_q.size() == 4) begin void'(m_q.pop_front()); m_ovf = 1; end
        m_q.push_back({m_count, m_tick - 32'(span)});
      end
      if (byte_stb) begin
        m_count = m_count + 16'd1;
        if (m_mode) begin m_snap_v = 1; m_snap_pos = m_count; m_snap_tick = m_tick; end
      end
      late_side = 64'd9000000 + longint'(margin_us) * longint'(baud_hz);
      budget    = 2 * longint'(rdt_code) * longint'(baud_hz);
      m_mode    = late_side > budget;
      m_tick    = m_tick + 32'd1;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(tick_now == m_tick, "R1", "tick_now", tick_now, m_tick);
      chk(rx_count == m_count, "R2", "rx_count", 32'(rx_count), 32'(m_count));
      chk(per_byte_mode == m_mode, "R3 R4", "per_byte_mode", 32'(per_byte_mode), 32'(m_mode));
      chk(fifo_overflow == m_ovf, "R10", "fifo_overflow", 32'(fifo_overflow), 32'(m_ovf));
      chk(lookup_valid == e_valid, "R11", "lookup_valid", 32'(lookup_valid), 32'(e_valid));
      chk(lookup_found == e_found, e_tag, "lookup_found", 32'(lookup_found), 32'(e_found));
      chk(lookup_tick == e_tick, e_tag, "lookup_tick", lookup_tick, e_tick);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte();
    rx_line = 1'b0; wait_n(3);
    rx_line = 1'b1; wait_n(1);
    byte_stb = 1'b1; wait_n(1);
    byte_stb = 1'b0;
  endtask

  task automatic look(logic [15:0] pos);
    lookup_req = 1'b1; lookup_pos = pos; wait_n(1);
    lookup_req = 1'b0; wait_n(1);
  endtask

  initial begin
    wait_n(4);
    rst_n = 1'b1;                              // reset state compared above (R1, R2, R3)
    wait_n(3);
    // Per-byte mode at 9600 baud, 250 us delay (R3, R5, R6)
    repeat (3) send_byte();
    look(16'd3);                               // R6 hit
    look(16'd2);                               // R6 miss
    look(16'd3);                               // R6 not consumed
    send_byte();
    look(16'd3);                               // R5 overwritten, miss
    wait_n(25);
    // Quiet-line mode at 1 Mbaud (R3, R7, R8, R9)
    baud_hz = 22'd1000000; wait_n(3);
    repeat (2) send_byte(); wait_n(25);
    repeat (3) send_byte(); wait_n(25);
    look(16'd9);                               // R9 out of order
    look(16'd6);
    look(16'd6);                               // R9 removed
    send_byte(); wait_n(5);
    rx_line = 1'b0; wait_n(2); rx_line = 1'b1; // R7 cancel
    wait_n(30);
    look(16'd10);
    // Overflow (R10)
    repeat (5) begin send_byte(); wait_n(25); end
    look(16'd11);
    look(16'd15);
    look(16'd12);
    // Mode rule corners (R3, R4)
    rdt_code = 8'd1; wait_n(3);
    rdt_code = 8'd125; baud_hz = 22'd57600; wait_n(3);
    margin_us = 10'd100; wait_n(3);
    baud_hz = 22'd9600; margin_us = 10'd20; rdt_code = 8'd254; wait_n(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule